// File: doc/BRIEF.md
# Four-way lockable instruction cache

This block is a read-only instruction cache with four ways, placed between an instruction fetch port and a memory port that returns 64-bit beats. A fetch presents a 32-bit physical address. The address splits into a 20-bit tag, a 4 KB sub-bank number, a set number and a word select. The stored tags of all four ways are compared at once. A match returns the selected 64-bit word on the next cycle. On a miss, a victim way is picked by least-recently-used order, and any way the lock mask protects is passed over. The whole 32-byte line is then refilled from memory, and the fetch is answered as soon as its own word arrives.

A protection unit supplies a page-valid flag. While the cache is enabled, a fetch without a valid page raises a fault instead of being served. With the cache disabled, or with every way of the target set locked, fetches are served straight from memory and nothing is allocated. A synchronous invalidate input drops every line at once. The arrays are reachable only through the fetch path.

Top module: `icache_lock4`

## Requirements
- R1: The tag is address bits 31:14 followed by bits 11:10. Bits 13:12 pick the sub-bank, bits 9:5 pick the set within it, bits 4:3 pick the 64-bit word, and bits 2:0 are ignored. Addresses that differ only in the sub-bank, or only in tag bits 11:10, occupy separate lines.
- R2: An enabled fetch with page_ok high that matches a valid line raises rsp_valid with the stored word in the cycle after acceptance, and makes no memory request.
- R3: A miss holds mem_req high with the line base address (bits 4:0 zero). It takes four beats, word 0 first. rsp_valid carries the requested word in the cycle after the beat that delivered it, and the line becomes valid only after the fourth beat.
- R4: The victim is the lowest-numbered invalid unlocked way if one exists. Otherwise it is the least recently used unlocked way. Hits and completed refills make a way the most recent.
- R5: A way whose lock_mask bit is 1 is never chosen as a victim, but it still hits.
- R6: When every way of the set is locked, a miss is served from memory and allocates nothing, so the same fetch misses again.
- R7: With cache_en=1 and page_ok=0, a fetch raises fetch_fault for one cycle in the cycle after acceptance. It raises no rsp_valid and makes no memory request.
- R8: With cache_en=0, every fetch is served from memory whatever the value of page_ok. It raises no fault and allocates nothing.
- R9: A one-cycle pulse on inval_all makes every line invalid, so the next fetch to a previously cached line misses.
- R10: After reset, fetch_ready=1, rsp_valid=0, fetch_fault=0, mem_req=0, and no line is valid. fetch_ready is low while a refill is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Cache enable |
| page_ok | input | 1 | Page definition valid for this fetch |
| lock_mask | input | 4 | One lock bit per way |
| inval_all | input | 1 | Invalidate every line |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 32 | Fetch physical address |
| fetch_ready | output | 1 | Block can accept a fetch |
| rsp_valid | output | 1 | Fetch data valid |
| rsp_data | output | 64 | Fetched instruction word |
| fetch_fault | output | 1 | Fetch rejected for missing page |
| mem_req | output | 1 | Refill request, held for the whole refill |
| mem_addr | output | 32 | Line base address of the refill |
| mem_rvalid | input | 1 | Refill beat valid |
| mem_rdata | input | 64 | Refill beat data |

## Verification
The assertions check the following on every cycle:
- An allocating miss never names a locked way as victim.
- At most one way matches.
- Hits and faults are answered in the following cycle without a memory request.
- The refill address is line aligned and stays steady.
- fetch_ready and mem_req are never high together.

Only the bench scenarios can show the rest. These are replacement order over a sequence of fetches, the absence of allocation when all ways are locked or the cache is off, the effect of invalidation, the separation of lines by sub-bank and by tag bits 11:10, and the exact cycle of a miss response relative to its beat.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 64;
  localparam int WAYS    = 4;
  localparam int TAG_W   = 20;
  localparam int BANK_W  = 2;
  localparam int SET_W   = 5;
  localparam int WSEL_W  = 2;
  localparam int OFF_W   = 3;
  localparam int IDX_W   = BANK_W + SET_W;
  localparam int LINES   = 1 << IDX_W;
  localparam int WPL     = 1 << WSEL_W;
  localparam int WAY_W   = $clog2(WAYS);
  localparam int LOFF_W  = WSEL_W + OFF_W;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [WSEL_W-1:0] wsel_t;
  typedef logic [WAY_W-1:0]  way_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic {S_IDLE, S_FILL} fsm_t;

  // tag joins the high bits with bits 11:10; bits 13:12 are the sub-bank
  function automatic tag_t addr_tag(input addr_t a);
    return {a[31:14], a[11:10]};
  endfunction

  // line index: sub-bank on top, set below
  function automatic idx_t addr_idx(input addr_t a);
    return {a[13:12], a[9:5]};
  endfunction

  function automatic wsel_t addr_word(input addr_t a);
    return a[4:3];
  endfunction

  function automatic addr_t line_base(input addr_t a);
    return {a[ADDR_W-1:LOFF_W], {LOFF_W{1'b0}}};
  endfunction
endpackage

// File: rtl/icache_tagstore.sv
module icache_tagstore
  import icache_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  idx_t            look_idx,
  input  tag_t            look_tag,
  input  logic [WAYS-1:0] lock_mask,
  output logic [WAYS-1:0] hit_vec,
  output logic            hit,
  output way_t            hit_way,
  output logic            vict_ok,
  output way_t            vict_way,
  input  logic            touch_en,
  input  idx_t            touch_idx,
  input  way_t            touch_way,
  input  logic            fill_en,
  input  idx_t            fill_idx,
  input  way_t            fill_way,
  input  tag_t            fill_tag,
  input  logic            inval_all
);
  tag_t             tag_q [WAYS][LINES];
  logic [LINES-1:0] vld_q [WAYS];
  way_t             age_q [LINES][WAYS];  // 0 = most recent

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[w][look_idx] && (tag_q[w][look_idx] == look_tag);
  end
  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = way_t'(w);
  end

  // victim: first invalid unlocked way, else oldest unlocked way
  always_comb begin
    logic found_inv;
    way_t best_age;
    found_inv = 1'b0;
    best_age  = '0;
    vict_ok   = 1'b0;
    vict_way  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!lock_mask[w] && !vld_q[w][look_idx] && !found_inv) begin
        found_inv = 1'b1;
        vict_ok   = 1'b1;
        vict_way  = way_t'(w);
      end
    end
    if (!found_inv) begin
      for (int w = 0; w < WAYS; w++) begin
        if (!lock_mask[w] && (!vict_ok || age_q[look_idx][w] > best_age)) begin
          vict_ok  = 1'b1;
          vict_way = way_t'(w);
          best_age = age_q[look_idx][w];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_way][fill_idx] <= fill_tag;
  end

  // invalidate is written last so it wins over a same-cycle fill
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) vld_q[w] <= '0;
    end else begin
      if (fill_en) vld_q[fill_way][fill_idx] <= 1'b1;
      if (inval_all)
        for (int w = 0; w < WAYS; w++) vld_q[w] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++)
        for (int w = 0; w < WAYS; w++) age_q[l][w] <= way_t'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (way_t'(w) == touch_way)
          age_q[touch_idx][w] <= '0;
        else if (age_q[touch_idx][w] < age_q[touch_idx][touch_way])
          age_q[touch_idx][w] <= age_q[touch_idx][w] + way_t'(1);
      end
    end
  end
endmodule

// File: rtl/icache_datastore.sv
module icache_datastore
  import icache_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  way_t              w_way,
  input  idx_t              w_idx,
  input  wsel_t             w_word,
  input  logic [DATA_W-1:0] w_data,
  input  way_t              r_way,
  input  idx_t              r_idx,
  input  wsel_t             r_word,
  output logic [DATA_W-1:0] r_data
);
  localparam int DEPTH = WAYS * LINES * WPL;
  localparam int AW    = WAY_W + IDX_W + WSEL_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  function automatic logic [AW-1:0] slot(input way_t w, input idx_t i, input wsel_t s);
    return {w, i, s};
  endfunction

  always_ff @(posedge clk) begin
    if (we) mem_q[slot(w_way, w_idx, w_word)] <= w_data;
  end

  assign r_data = mem_q[slot(r_way, r_idx, r_word)];
endmodule

// File: rtl/icache_lock4.sv
module icache_lock4
  import icache_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              page_ok,
  input  logic [WAYS-1:0]   lock_mask,
  input  logic              inval_all,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fetch_fault,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  fsm_t              state_q;
  addr_t             f_addr_q;
  way_t              f_vict_q;
  logic              f_alloc_q;
  wsel_t             beat_q;
  logic              rsp_valid_q, fault_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic [WAYS-1:0]   hit_vec;
  logic              hit, vict_ok;
  way_t              hit_way, vict_way;
  logic [DATA_W-1:0] rd_data;

  // named events, also watched by the checker
  logic accept, ev_fault, ev_hit, ev_miss, ev_alloc;
  logic beat_in, beat_last, beat_mine, fill_en, touch_en;

  assign accept    = fetch_req && (state_q == S_IDLE);
  assign ev_fault  = accept && cache_en && !page_ok;
  assign ev_hit    = accept && cache_en && page_ok && hit;
  assign ev_miss   = accept && !ev_fault && !ev_hit;
  assign ev_alloc  = ev_miss && cache_en && vict_ok;
  assign beat_in   = (state_q == S_FILL) && mem_rvalid;
  assign beat_last = beat_in && (beat_q == wsel_t'(WPL-1));
  assign beat_mine = beat_in && (beat_q == addr_word(f_addr_q));
  assign fill_en   = beat_last && f_alloc_q;
  assign touch_en  = ev_hit || fill_en;

  icache_tagstore u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_idx  (addr_idx(fetch_addr)),
    .look_tag  (addr_tag(fetch_addr)),
    .lock_mask (lock_mask),
    .hit_vec   (hit_vec),
    .hit       (hit),
    .hit_way   (hit_way),
    .vict_ok   (vict_ok),
    .vict_way  (vict_way),
    .touch_en  (touch_en),
    .touch_idx (ev_hit ? addr_idx(fetch_addr) : addr_idx(f_addr_q)),
    .touch_way (ev_hit ? hit_way : f_vict_q),
    .fill_en   (fill_en),
    .fill_idx  (addr_idx(f_addr_q)),
    .fill_way  (f_vict_q),
    .fill_tag  (addr_tag(f_addr_q)),
    .inval_all (inval_all)
  );

  icache_datastore u_data (
    .clk    (clk),
    .we     (beat_in && f_alloc_q),
    .w_way  (f_vict_q),
    .w_idx  (addr_idx(f_addr_q)),
    .w_word (beat_q),
    .w_data (mem_rdata),
    .r_way  (hit_way),
    .r_idx  (addr_idx(fetch_addr)),
    .r_word (addr_word(fetch_addr)),
    .r_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      f_addr_q    <= '0;
      f_vict_q    <= '0;
      f_alloc_q   <= 1'b0;
      beat_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      fault_q     <= 1'b0;
    end else begin
      rsp_valid_q <= ev_hit || beat_mine;
      fault_q     <= ev_fault;
      if (ev_hit)         rsp_data_q <= rd_data;
      else if (beat_mine) rsp_data_q <= mem_rdata;
      if (ev_miss) begin
        state_q   <= S_FILL;
        f_addr_q  <= fetch_addr;
        f_vict_q  <= vict_way;
        f_alloc_q <= ev_alloc;
        beat_q    <= '0;
      end else if (beat_in) begin
        beat_q <= beat_q + wsel_t'(1);
        if (beat_last) state_q <= S_IDLE;
      end
    end
  end

  assign fetch_ready = (state_q == S_IDLE);
  assign rsp_valid   = rsp_valid_q;
  assign rsp_data    = rsp_data_q;
  assign fetch_fault = fault_q;
  assign mem_req     = (state_q == S_FILL);
  assign mem_addr    = line_base(f_addr_q);
endmodule

// File: rtl/icache_lock4_chk.sv
module icache_lock4_chk
  import icache_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [WAYS-1:0]   lock_mask,
  input logic              ev_hit,
  input logic              ev_fault,
  input logic              ev_alloc,
  input way_t              vict_way,
  input logic [WAYS-1:0]   hit_vec,
  input logic              fetch_ready,
  input logic              rsp_valid,
  input logic              fetch_fault,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr
);
  a_r5_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |-> !lock_mask[vict_way]);

  a_r1_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> (rsp_valid && !mem_req && !fetch_fault));

  a_r7_fault_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> (fetch_fault && !rsp_valid && !mem_req));

  a_r3_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[LOFF_W-1:0] == '0));

  a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> $stable(mem_addr));

  a_r10_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && fetch_ready));
endmodule

bind icache_lock4 icache_lock4_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lock_mask   (lock_mask),
  .ev_hit      (ev_hit),
  .ev_fault    (ev_fault),
  .ev_alloc    (ev_alloc),
  .vict_way    (vict_way),
  .hit_vec     (hit_vec),
  .fetch_ready (fetch_ready),
  .rsp_valid   (rsp_valid),
  .fetch_fault (fetch_fault),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr)
);

// File: tb/tb_icache_lock4.sv
module tb_icache_lock4;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b1, page_ok = 1'b1, inval_all = 1'b0;
  logic [3:0]  lock_mask = 4'b0000;
  logic        fetch_req = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_ready, rsp_valid, fetch_fault, mem_req;
  logic [63:0] rsp_data;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;

  int n_checks = 0, n_fail = 0, mem_txn = 0;
  logic [31:0] gen = 32'h0;
  logic        r_valid, r_fault;
  logic [63:0] r_data;
  int          r_lat, r_txn;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_lock4 dut (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .page_ok(page_ok),
    .lock_mask(lock_mask), .inval_all(inval_all), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_ready(fetch_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .fetch_fault(fetch_fault), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory image: word content derived from its 8-byte address and a generation
  function automatic logic [63:0] mword(input logic [31:0] a, input logic [31:0] g);
    logic [31:0] wa;
    wa = {a[31:3], 3'b000};
    return {wa ^ g, ~wa};
  endfunction

  // memory model: one idle cycle, then four beats, word 0 first
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && rst_n) begin
        logic [31:0] base;
        base = mem_addr;
        mem_txn++;
        @(negedge clk);
        for (int b = 0; b < 4; b++) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mword(base + 32'(b * 8), gen);
          @(negedge clk);
        end
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] a);
    int t0;
    int lat;
    while (!fetch_ready) @(negedge clk);
    t0 = mem_txn;
    fetch_req = 1'b1;
    fetch_addr = a;
    @(negedge clk);
    fetch_req = 1'b0;
    lat = 0;
    while (!(rsp_valid || fetch_fault) && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    r_valid = rsp_valid;
    r_fault = fetch_fault;
    r_data  = rsp_data;
    r_lat   = lat;
    while (!fetch_ready) @(negedge clk);
    r_txn = mem_txn - t0;
  endtask

  task automatic expect_hit(input logic [31:0] a, input logic [31:0] g, input string req);
    fetch(a);
    check(r_valid && !r_fault && r_lat == 0, req, 64'(r_lat), 64'd0);
    check(r_txn == 0, req, 64'(r_txn), 64'd0);
    check(r_data == mword(a, g), req, r_data, mword(a, g));
  endtask

  task automatic expect_miss(input logic [31:0] a, input logic [31:0] g, input string req);
    int want_lat;
    want_lat = 2 + int'(a[4:3]);
    fetch(a);
    check(r_valid && !r_fault && r_lat == want_lat, req, 64'(r_lat), 64'(want_lat));
    check(r_txn == 1, req, 64'(r_txn), 64'd1);
    check(r_data == mword(a, g), req, r_data, mword(a, g));
  endtask

  task automatic pulse_inval();
    @(negedge clk);
    inval_all = 1'b1;
    @(negedge clk);
    inval_all = 1'b0;
  endtask

  task automatic t_reset();
    check(fetch_ready === 1'b1, "R10 ready", 64'(fetch_ready), 64'd1);
    check(rsp_valid === 1'b0 && fetch_fault === 1'b0, "R10 idle outputs",
          64'({rsp_valid, fetch_fault}), 64'd0);
    check(mem_req === 1'b0, "R10 no request", 64'(mem_req), 64'd0);
  endtask

  task automatic t_miss_hit();
    gen = 32'h0;
    expect_miss(32'h0001_0010, 32'h0, "R3 miss word2");
    gen = 32'h1111_0000;
    expect_hit(32'h0001_0008, 32'h0, "R2 hit word1");
    expect_hit(32'h0001_001C, 32'h0, "R1 low bits ignored");
    expect_miss(32'h0001_0118, gen, "R3 miss word3");
  endtask

  task automatic t_fields();
    gen = 32'h0000_0A00;
    expect_miss(32'h0002_1000, gen, "R1 bank1 fill");
    expect_miss(32'h0002_2000, gen, "R1 bank2 fill");
    expect_miss(32'h0002_0400, gen, "R1 tag bits 11:10 fill");
    expect_miss(32'h0002_0000, gen, "R1 tag bits 11:10 fill b");
    gen = 32'h0000_0B00;
    expect_hit(32'h0002_1000, 32'h0000_0A00, "R1 bank1 kept");
    expect_hit(32'h0002_2000, 32'h0000_0A00, "R1 bank2 kept");
    expect_hit(32'h0002_0400, 32'h0000_0A00, "R1 tag split kept");
    expect_hit(32'h0002_0000, 32'h0000_0A00, "R1 tag split kept b");
  endtask

  task automatic t_lru();
    pulse_inval();
    gen = 32'h0000_0300;
    expect_miss(32'h0010_0060, gen, "R4 fill A");
    expect_miss(32'h0020_0060, gen, "R4 fill B");
    expect_miss(32'h0030_0060, gen, "R4 fill C");
    expect_miss(32'h0040_0060, gen, "R4 fill D");
    expect_hit (32'h0010_0060, gen, "R4 touch A");
    expect_miss(32'h0050_0060, gen, "R4 fill E evicts B");
    expect_hit (32'h0010_0060, gen, "R4 A kept");
    expect_hit (32'h0030_0060, gen, "R4 C kept");
    expect_hit (32'h0040_0060, gen, "R4 D kept");
    expect_miss(32'h0020_0060, gen, "R4 B was evicted");
  endtask

  task automatic t_lock();
    pulse_inval();
    gen = 32'h0000_0400;
    expect_miss(32'h0010_0080, gen, "R5 fill A");
    expect_miss(32'h0020_0080, gen, "R5 fill B");
    expect_miss(32'h0030_0080, gen, "R5 fill C");
    expect_miss(32'h0040_0080, gen, "R5 fill D");
    expect_hit (32'h0010_0080, gen, "R5 touch A");
    lock_mask = 4'b0010;
    expect_miss(32'h0050_0080, gen, "R5 fill E skips locked B");
    expect_hit (32'h0020_0080, gen, "R5 locked B still hits");
    expect_miss(32'h0030_0080, gen, "R5 C was evicted");
    lock_mask = 4'b0000;
  endtask

  task automatic t_all_locked();
    pulse_inval();
    lock_mask = 4'b1111;
    gen = 32'h0000_0500;
    expect_miss(32'h0060_00A8, gen, "R6 served from memory");
    expect_miss(32'h0060_00A8, gen, "R6 nothing allocated");
    lock_mask = 4'b0000;
  endtask

  task automatic t_fault();
    page_ok = 1'b0;
    fetch(32'h0070_0000);
    check(r_fault && !r_valid && r_lat == 0, "R7 fault pulse", 64'({r_fault, r_valid}), 64'd2);
    check(r_txn == 0, "R7 no memory access", 64'(r_txn), 64'd0);
    @(negedge clk);
    check(fetch_fault === 1'b0, "R7 one cycle", 64'(fetch_fault), 64'd0);
    page_ok = 1'b1;
  endtask

  task automatic t_disabled();
    cache_en = 1'b0;
    page_ok  = 1'b0;
    gen = 32'h0000_0600;
    expect_miss(32'h0080_0040, gen, "R8 disabled served");
    expect_miss(32'h0080_0040, gen, "R8 disabled not allocated");
    cache_en = 1'b1;
    page_ok  = 1'b1;
    expect_miss(32'h0080_0040, gen, "R8 enabled still cold");
  endtask

  task automatic t_inval();
    gen = 32'h0000_0700;
    expect_miss(32'h0090_0020, gen, "R9 fill");
    expect_hit (32'h0090_0020, gen, "R9 cached");
    pulse_inval();
    expect_miss(32'h0090_0020, gen, "R9 invalidated");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_hit();
    t_fields();
    t_lru();
    t_lock();
    t_all_locked();
    t_fault();
    t_disabled();
    t_inval();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule